// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block gathers every external interruption condition that can be pending for one processor and, each time the processor asks, grants exactly one of them. Conditions arrive as short request pulses. Two kinds of condition can come from several processors at once, so each of them is kept as a per-processor bitmap with a summary flag. The two timer conditions are not stored at all. They are recomputed every cycle from the time-of-day value, the comparator register and the signed CPU-timer value.

An arbitration request is honoured only when the global external-enable input is high. The arbiter considers only conditions whose own mask bit is set, picks the highest-priority one, updates its pending state, and returns a one-cycle take strobe. With the strobe it returns a 16-bit interruption code, a 16-bit originating-address field and a 32-bit parameter field. Storing and loading program status words is done by the consumer of these outputs.

Top module: `ext_irq_arbiter`

## Requirements
- R1: An arbitration request (`arb_req` high with `ext_enable` high) produces at most one `take` pulse, registered on the next clock edge. Every condition that was not granted stays pending and is served on a later request.
- R2: Priority is fixed, highest first: interrupt key, malfunction alert, emergency signal, external call, clock comparator, CPU timer, interval timer, service signal. Mask bit `cls_mask[i]` enables class i in that order: bit 0 is the key and bit 7 is the service signal. A masked class keeps its pending state.
- R3: While `ext_enable` is low, no `take` is produced and no pending state changes because of `arb_req`.
- R4: For malfunction alert and emergency signal, the lowest-numbered processor whose bit is set is served. Only that bit is cleared. For an emergency signal, the processor number appears, zero-extended, in `int_addr`.
- R5: After a bitmap bit is served, the summary flag of that class stays set if any other bit is still set, and clears otherwise.
- R6: If a bitmap class wins while its summary is set but no bit is set, its summary is cleared and nothing is taken on that request.
- R7: The clock-comparator condition holds only when `tod` is strictly greater than `clkc`, compared unsigned.
- R8: The CPU-timer condition holds whenever `cpu_timer` bit 63 is set. Taking either timer condition does not clear it.
- R9: `int_addr` is zero unless the taken code is external call or emergency signal. For an external call it carries the address latched with the last `xcall_req`.
- R10: Taking the interval timer clears its pending flag. Taking the service signal clears its pending flag and its stored parameter, and reports that parameter in `int_parm`. `int_parm` is zero for every other class.
- R11: Codes are 0x0040 key, 0x1200 malfunction alert, 0x1201 emergency signal, 0x1202 external call, 0x1004 clock comparator, 0x1005 CPU timer, 0x0080 interval timer, 0x2401 service signal. `int_code`, `int_addr` and `int_parm` are zero in any cycle without `take`.
- R12: After a synchronous reset, nothing is pending and all outputs are zero.
- R13: A new request for a class that arrives in the same cycle as that class is taken wins over the clear: the condition stays pending with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_req | input | 1 | Request one arbitration this cycle |
| ext_enable | input | 1 | Global external-interruption enable |
| cls_mask | input | 8 | Per-class enable, bit i = priority rank i |
| key_req | input | 1 | Interrupt-key request pulse |
| malf_post | input | 1 | Post malfunction-alert sources (sets summary) |
| malf_src | input | NCPU | Processor bits to add to malfunction bitmap |
| emer_post | input | 1 | Post emergency-signal sources (sets summary) |
| emer_src | input | NCPU | Processor bits to add to emergency bitmap |
| xcall_req | input | 1 | External-call request pulse |
| xcall_src | input | 16 | Originating address for the external call |
| tod | input | 64 | Time-of-day value |
| clkc | input | 64 | Clock-comparator register |
| cpu_timer | input | 64 | Signed CPU-timer value |
| itmr_req | input | 1 | Interval-timer request pulse |
| svc_req | input | 1 | Service-signal request pulse |
| svc_parm_in | input | 32 | Service-signal parameter |
| take | output | 1 | One-cycle grant strobe |
| int_code | output | 16 | Interruption code of the granted class |
| int_addr | output | 16 | Originating-address field |
| int_parm | output | 32 | Parameter field |

## Verification
The bench drains a fully loaded set of conditions one request at a time. A broken priority chain would show up as a code out of order, and a design that cleared more than one condition per request would skip one. It posts an emergency summary with an empty bitmap ahead of a pending external call, so a design that fell through to the next class would take the call one request early. It also sets the comparator exactly equal to the time of day, where a non-strict compare would fire, and repeats timer takes to catch a design that clears a timer. It raises a new service request in the same cycle as the grant, where a clear-wins update would lose the second parameter, and it checks that a malfunction alert reports address zero even though a processor number was selected.

// File: rtl/ext_irq_pkg.sv
// Shared constants for the external interrupt arbiter.
// Assumes the class ranks below are also the priority order (0 highest).
package ext_irq_pkg;
    localparam int NCLS = 8;

    typedef enum logic [2:0] {
        CL_KEY   = 3'd0,
        CL_MALF  = 3'd1,
        CL_EMER  = 3'd2,
        CL_XCALL = 3'd3,
        CL_CLKC  = 3'd4,
        CL_CPUT  = 3'd5,
        CL_ITMR  = 3'd6,
        CL_SVC   = 3'd7
    } cls_e;

    localparam logic [15:0] CODE_KEY   = 16'h0040;
    localparam logic [15:0] CODE_MALF  = 16'h1200;
    localparam logic [15:0] CODE_EMER  = 16'h1201;
    localparam logic [15:0] CODE_XCALL = 16'h1202;
    localparam logic [15:0] CODE_CLKC  = 16'h1004;
    localparam logic [15:0] CODE_CPUT  = 16'h1005;
    localparam logic [15:0] CODE_ITMR  = 16'h0080;
    localparam logic [15:0] CODE_SVC   = 16'h2401;

    // Map a class rank to its interruption code.
    function automatic logic [15:0] code_of(cls_e c);
        case (c)
            CL_KEY:   return CODE_KEY;
            CL_MALF:  return CODE_MALF;
            CL_EMER:  return CODE_EMER;
            CL_XCALL: return CODE_XCALL;
            CL_CLKC:  return CODE_CLKC;
            CL_CPUT:  return CODE_CPUT;
            CL_ITMR:  return CODE_ITMR;
            default:  return CODE_SVC;
        endcase
    endfunction
endpackage

// File: rtl/ext_irq_lowbit.sv
// Combinational lowest-set-bit encoder.
// Gives the index and one-hot mask of the lowest set bit of vec.
// Assumes W >= 2; outputs are zero when vec is zero.
module ext_irq_lowbit #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // Isolate the lowest set bit with two's complement.
    always_comb onehot = vec & (~vec + W'(1));
endmodule

// File: rtl/ext_irq_prio.sv
// Fixed-priority selector over the eight classes; rank 0 wins.
// Assumes elig already includes pending state and per-class masks.
module ext_irq_prio
    import ext_irq_pkg::*;
(
    input  logic [NCLS-1:0] elig,
    output logic            any,
    output cls_e            win,
    output logic [NCLS-1:0] grant
);
    // Pick the lowest-ranked eligible class.
    always_comb begin
        win = CL_SVC;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (elig[i]) win = cls_e'(i);
        end
    end

    // Summarise and expand the pick into a grant vector.
    always_comb begin
        any   = |elig;
        grant = any ? (NCLS'(1) << win) : '0;
    end
endmodule

// File: rtl/ext_irq_bitmap_src.sv
// One multi-source condition class held as a per-processor bitmap
// plus a summary flag. When served, it clears the lowest set bit and
// keeps the summary only if other bits remain. Posting always sets the
// summary, even with an empty vector; a served empty class drops it.
// Assumes serve is asserted only when this class wins an arbitration.
module ext_irq_bitmap_src #(
    parameter int NCPU = 8,
    localparam int IW  = $clog2(NCPU)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post,
    input  logic [NCPU-1:0] post_vec,
    input  logic            serve,
    output logic            pending,
    output logic            found,
    output logic [IW-1:0]   idx
);
    logic [NCPU-1:0] bits_q;
    logic [NCPU-1:0] low_oh;
    logic [NCPU-1:0] bits_left;
    logic            sum_q;

    ext_irq_lowbit #(.W(NCPU)) u_low (
        .vec    (bits_q),
        .found  (found),
        .idx    (idx),
        .onehot (low_oh)
    );

    // Bits that survive a serve of this class.
    always_comb bits_left = serve ? (bits_q & ~low_oh) : bits_q;

    // Update the bitmap and its summary; new posts win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            sum_q  <= 1'b0;
        end else begin
            bits_q <= bits_left | (post ? post_vec : '0);
            if (post)
                sum_q <= 1'b1;
            else if (serve)
                sum_q <= |bits_left;
        end
    end

    assign pending = sum_q;

    // R4
    served_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && found && !(post && post_vec[idx])) |=> !bits_q[$past(idx)]);

    // R5
    summary_follows_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && found && !post) |=> (sum_q == (bits_q != '0)));

    // R6
    empty_summary_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && !found && !post) |=> !sum_q);
endmodule

// File: rtl/ext_irq_arbiter.sv
// External interrupt priority arbiter for one processor.
// It holds pending single-source flags and two per-processor bitmaps.
// It derives the two timer conditions each cycle. On an enabled
// request it grants one class, registering take/code/addr/parm for
// one cycle. Assumes 2 <= NCPU <= 64 and that request pulses are
// synchronous to clk.
module ext_irq_arbiter
    import ext_irq_pkg::*;
#(
    parameter int NCPU = 8,
    localparam int IW  = $clog2(NCPU)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arb_req,
    input  logic            ext_enable,
    input  logic [7:0]      cls_mask,
    input  logic            key_req,
    input  logic            malf_post,
    input  logic [NCPU-1:0] malf_src,
    input  logic            emer_post,
    input  logic [NCPU-1:0] emer_src,
    input  logic            xcall_req,
    input  logic [15:0]     xcall_src,
    input  logic [63:0]     tod,
    input  logic [63:0]     clkc,
    input  logic [63:0]     cpu_timer,
    input  logic            itmr_req,
    input  logic            svc_req,
    input  logic [31:0]     svc_parm_in,
    output logic            take,
    output logic [15:0]     int_code,
    output logic [15:0]     int_addr,
    output logic [31:0]     int_parm
);
    logic            key_q, xc_q, it_q, sv_q;
    logic [15:0]     xc_addr_q;
    logic [31:0]     sv_parm_q;
    logic            take_q;
    logic [15:0]     code_q, addr_q;
    logic [31:0]     parm_q;

    logic            malf_pend, malf_found;
    logic [IW-1:0]   malf_idx;
    logic            emer_pend, emer_found;
    logic [IW-1:0]   emer_idx;

    logic            clkc_hit, cput_hit, fire, any;
    logic [NCLS-1:0] pend, elig, grant, serve;
    cls_e            win;
    logic            take_d;
    logic [15:0]     addr_d;

    // Timer conditions are level-derived and never stored.
    always_comb begin
        clkc_hit = tod > clkc;
        cput_hit = cpu_timer[63];
    end

    // Assemble pending vector in priority order and apply masks.
    always_comb begin
        pend  = {sv_q, it_q, cput_hit, clkc_hit, xc_q, emer_pend, malf_pend, key_q};
        elig  = pend & cls_mask;
        fire  = arb_req && ext_enable;
        serve = fire ? grant : '0;
    end

    ext_irq_prio u_prio (
        .elig  (elig),
        .any   (any),
        .win   (win),
        .grant (grant)
    );

    ext_irq_bitmap_src #(.NCPU(NCPU)) u_malf (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (malf_post),
        .post_vec (malf_src),
        .serve    (serve[CL_MALF]),
        .pending  (malf_pend),
        .found    (malf_found),
        .idx      (malf_idx)
    );

    ext_irq_bitmap_src #(.NCPU(NCPU)) u_emer (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (emer_post),
        .post_vec (emer_src),
        .serve    (serve[CL_EMER]),
        .pending  (emer_pend),
        .found    (emer_found),
        .idx      (emer_idx)
    );

    // Decide whether a grant results in a take, and the address field.
    always_comb begin
        take_d = fire && any;
        if (win == CL_MALF && !malf_found) take_d = 1'b0;
        if (win == CL_EMER && !emer_found) take_d = 1'b0;
        case (win)
            CL_EMER:  addr_d = {{(16 - IW){1'b0}}, emer_idx};
            CL_XCALL: addr_d = xc_addr_q;
            default:  addr_d = '0;
        endcase
    end

    // Single-source pending flags; a new request beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q     <= 1'b0;
            xc_q      <= 1'b0;
            xc_addr_q <= '0;
            it_q      <= 1'b0;
            sv_q      <= 1'b0;
            sv_parm_q <= '0;
        end else begin
            key_q <= key_req  | (key_q & ~serve[CL_KEY]);
            xc_q  <= xcall_req | (xc_q & ~serve[CL_XCALL]);
            it_q  <= itmr_req | (it_q & ~serve[CL_ITMR]);
            sv_q  <= svc_req  | (sv_q & ~serve[CL_SVC]);
            if (xcall_req) xc_addr_q <= xcall_src;
            if (svc_req)
                sv_parm_q <= svc_parm_in;
            else if (serve[CL_SVC])
                sv_parm_q <= '0;
        end
    end

    // Registered grant outputs, zero when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            code_q <= '0;
            addr_q <= '0;
            parm_q <= '0;
        end else begin
            take_q <= take_d;
            code_q <= take_d ? code_of(win) : '0;
            addr_q <= take_d ? addr_d : '0;
            parm_q <= (take_d && win == CL_SVC) ? sv_parm_q : '0;
        end
    end

    assign take     = take_q;
    assign int_code = code_q;
    assign int_addr = addr_q;
    assign int_parm = parm_q;

    // R1
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(serve));

    // R3
    take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(arb_req && ext_enable));

    // R9
    addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && int_code != CODE_XCALL && int_code != CODE_EMER) |-> (int_addr == 16'h0));

    // R7
    clkc_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && int_code == CODE_CLKC) |-> $past(tod > clkc));

    // R8
    cput_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && int_code == CODE_CPUT) |-> $past(cpu_timer[63]));

    // R10
    svc_parm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve[CL_SVC] && !svc_req) |=> (sv_parm_q == 32'h0 && !sv_q));

    // R11
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (int_code == 16'h0 && int_addr == 16'h0 && int_parm == 32'h0));
endmodule

// File: tb/sim_ext_irq_arbiter.sv
`timescale 1ns/100ps
module sim_ext_irq_arbiter;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arb_req = 0, ext_enable = 1;
    logic [7:0]  cls_mask = 8'hFF;
    logic        key_req = 0, malf_post = 0, emer_post = 0;
    logic [N-1:0] malf_src = '0, emer_src = '0;
    logic        xcall_req = 0;
    logic [15:0] xcall_src = '0;
    logic [63:0] tod = '0, clkc = '1, cpu_timer = '0;
    logic        itmr_req = 0, svc_req = 0;
    logic [31:0] svc_parm_in = '0;
    logic        take;
    logic [15:0] int_code, int_addr;
    logic [31:0] int_parm;

    int checks = 0, failures = 0;
    string cur_req = "R12";
    bit finished = 0;

    always #2.5 clk = ~clk;

    ext_irq_arbiter #(.NCPU(N)) u0 (
        .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .ext_enable(ext_enable),
        .cls_mask(cls_mask), .key_req(key_req), .malf_post(malf_post),
        .malf_src(malf_src), .emer_post(emer_post), .emer_src(emer_src),
        .xcall_req(xcall_req), .xcall_src(xcall_src), .tod(tod), .clkc(clkc),
        .cpu_timer(cpu_timer), .itmr_req(itmr_req), .svc_req(svc_req),
        .svc_parm_in(svc_parm_in), .take(take), .int_code(int_code),
        .int_addr(int_addr), .int_parm(int_parm)
    );

    // Reference model state, behavioural.
    bit          m_key, m_msum, m_esum, m_xc, m_it, m_sv;
    bit [N-1:0]  m_malf, m_emer;
    int          m_xca;
    longint unsigned m_svp;
    bit          e_take;
    int          e_code, e_addr;
    longint unsigned e_parm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 0; m_msum = 0; m_esum = 0; m_xc = 0; m_it = 0; m_sv = 0;
            m_malf = '0; m_emer = '0; m_xca = 0; m_svp = 0;
            e_take = 0; e_code = 0; e_addr = 0; e_parm = 0;
        end else begin
            bit p[8];
            int w;
            e_take = 0; e_code = 0; e_addr = 0; e_parm = 0;
            p[0] = m_key; p[1] = m_msum; p[2] = m_esum; p[3] = m_xc;
            p[4] = (tod > clkc); p[5] = ($signed(cpu_timer) < 0);
            p[6] = m_it; p[7] = m_sv;
            w = -1;
            if (arb_req && ext_enable)
                for (int i = 0; i < 8; i++)
                    if (w < 0 && p[i] && cls_mask[i]) w = i;
            case (w)
                0: begin e_take = 1; e_code = 'h0040; m_key = 0; end
                1, 2: begin
                    int b;
                    bit [N-1:0] v;
                    v = (w == 1) ? m_malf : m_emer;
                    b = -1;
                    for (int j = 0; j < N; j++) if (b < 0 && v[j]) b = j;
                    if (b >= 0) begin
                        v[b] = 0;
                        e_take = 1;
                        e_code = (w == 1) ? 'h1200 : 'h1201;
                        e_addr = (w == 1) ? 0 : b;
                    end
                    if (w == 1) begin m_malf = v; m_msum = (v != 0); end
                    else begin m_emer = v; m_esum = (v != 0); end
                end
                3: begin e_take = 1; e_code = 'h1202; e_addr = m_xca; m_xc = 0; end
                4: begin e_take = 1; e_code = 'h1004; end
                5: begin e_take = 1; e_code = 'h1005; end
                6: begin e_take = 1; e_code = 'h0080; m_it = 0; end
                7: begin e_take = 1; e_code = 'h2401; e_parm = m_svp; m_sv = 0; m_svp = 0; end
                default: ;
            endcase
            if (key_req) m_key = 1;
            if (malf_post) begin m_malf |= malf_src; m_msum = 1; end
            if (emer_post) begin m_emer |= emer_src; m_esum = 1; end
            if (xcall_req) begin m_xc = 1; m_xca = xcall_src; end
            if (itmr_req) m_it = 1;
            if (svc_req) begin m_sv = 1; m_svp = svc_parm_in; end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (take !== e_take || int_code !== 16'(e_code) ||
                int_addr !== 16'(e_addr) || int_parm !== 32'(e_parm)) begin
                failures++;
                $display("FAIL %s t=%0t act take=%0b code=%h addr=%h parm=%h exp take=%0b code=%h addr=%h parm=%h",
                         cur_req, $time, take, int_code, int_addr, int_parm,
                         e_take, 16'(e_code), 16'(e_addr), 32'(e_parm));
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulses();
        key_req = 0; malf_post = 0; emer_post = 0; xcall_req = 0;
        itmr_req = 0; svc_req = 0; malf_src = '0; emer_src = '0;
    endtask

    task automatic arb(int n);
        arb_req = 1; tick(n); arb_req = 0; tick(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        cur_req = "R12";
        rst_n = 1; tick(2);

        // R11: each class alone
        cur_req = "R11";
        key_req = 1; tick(); clear_pulses(); arb(1);
        malf_post = 1; malf_src = 8'h08; tick(); clear_pulses(); arb(1);
        emer_post = 1; emer_src = 8'h20; tick(); clear_pulses(); arb(1);
        xcall_req = 1; xcall_src = 16'h0ABC; tick(); clear_pulses(); arb(1);
        itmr_req = 1; tick(); clear_pulses(); arb(1);
        svc_req = 1; svc_parm_in = 32'h0000_5A5A; tick(); clear_pulses(); arb(1);

        // R2 / R1: everything at once, drained in order
        cur_req = "R2";
        key_req = 1; malf_post = 1; malf_src = 8'h10; emer_post = 1; emer_src = 8'h06;
        xcall_req = 1; xcall_src = 16'h0033; itmr_req = 1; svc_req = 1;
        svc_parm_in = 32'h0000_1234; tod = 64'd5; clkc = 64'd4; cpu_timer = '1;
        tick(); clear_pulses();
        arb(5);
        cur_req = "R8";
        arb_req = 1; tick(2); tod = 0; tick(2); cpu_timer = 0; tick(3); arb_req = 0; tick();

        // R4 / R5: several emergency sources, lowest first
        cur_req = "R4";
        emer_post = 1; emer_src = 8'hA4; tick(); clear_pulses();
        arb(1);
        cur_req = "R5";
        arb(3);
        // R9: malfunction alert reports address zero
        cur_req = "R9";
        malf_post = 1; malf_src = 8'h81; tick(); clear_pulses(); arb(3);

        // R6: empty emergency summary ahead of an external call
        cur_req = "R6";
        emer_post = 1; emer_src = 8'h00; xcall_req = 1; xcall_src = 16'h0777;
        tick(); clear_pulses(); arb(1); arb(1); arb(1);

        // R3: global enable low, then masking
        cur_req = "R3";
        key_req = 1; itmr_req = 1; tick(); clear_pulses();
        ext_enable = 0; arb(3); ext_enable = 1;
        cur_req = "R2";
        cls_mask = 8'hFE; arb(2); cls_mask = 8'hFF; arb(2);

        // R7: equal does not fire, greater does
        cur_req = "R7";
        tod = 64'h8000_0000_0000_0010; clkc = 64'h8000_0000_0000_0010; arb(2);
        tod = 64'h8000_0000_0000_0011; arb(2);
        tod = 64'h0000_0000_0000_0001; clkc = 64'hFFFF_FFFF_FFFF_FFFF; arb(1);

        // R8: negative CPU timer persists across takes
        cur_req = "R8";
        cpu_timer = 64'h8000_0000_0000_0000; arb(3);
        cpu_timer = 64'h7FFF_FFFF_FFFF_FFFF; arb(1);

        // R10: service parameter reported then cleared
        cur_req = "R10";
        svc_req = 1; svc_parm_in = 32'hDEAD_BEEF; tick(); clear_pulses(); arb(1); arb(1);

        // R13: new request in the take cycle survives
        cur_req = "R13";
        svc_req = 1; svc_parm_in = 32'h1111_0000; tick(); clear_pulses();
        arb_req = 1; svc_req = 1; svc_parm_in = 32'h2222_0000; itmr_req = 1;
        tick(); clear_pulses(); tick(3); arb_req = 0; tick();

        // R1: masked-off key stays pending over many requests
        cur_req = "R1";
        key_req = 1; tick(); clear_pulses(); cls_mask = 8'h00; arb(4);
        cls_mask = 8'hFF; arb(2);

        // R12: reset mid-run clears pending state
        cur_req = "R12";
        key_req = 1; itmr_req = 1; tick(); clear_pulses();
        rst_n = 0; tick(2); rst_n = 1; arb(2);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule